// File: doc/BRIEF.md
# Entropy Reseed Interval Counter with Redundant Count

This block counts update events of an internal pseudo-random generator and asks for fresh entropy once a programmable number of updates has been seen. Each `tick_i` pulse is one generator update. When the running count has reached the programmed interval, `reseed_req_o` rises and stays high until the entropy side answers with `reseed_ack_i`. The acknowledge clears the count and counting starts over.

The 16-bit interval is held in a shadowed register. A new value takes effect only after two back-to-back writes carry the same data. A differing second write throws the staged value away and raises a recoverable error pulse. Software can lock the interval by writing 0 to a lock port, and the lock holds until reset. The stored interval keeps an inverted shadow copy. The count is held in two copies. A disagreement between either pair latches a fatal fault, and the control state machine then parks in a fault state.

The control state machine has three named states. COUNT is the reset state, in which ticks accumulate. REQUEST is the state in which the reseed request is held. FAULT is the terminal state after a fatal fault. It has four transitions:
- COUNT to REQUEST, when the count is at or above the interval.
- REQUEST to COUNT, on the acknowledge.
- COUNT or REQUEST to FAULT, when any fatal flag is set.
- Any unused encoding to FAULT.

Top module: `reseed_guard`

## Requirements
- R1: After reset the interval reads 0x0100, the write enable `wen_o` is 1, the count is 0, the request is low and all error outputs are 0.
- R2: An interval write (`ival_wr_i` high for one cycle) only stages its data. The interval changes when the next interval write carries the same data, and the new value is visible on `ival_o` in the cycle after that second write.
- R3: When a second write differs from the staged data, `ival_o` keeps its old value and `recov_err_o` is high for exactly one cycle. The staged data is discarded, so the differing write itself becomes the newly staged value.
- R4: A lock write (`lock_wr_i`) with `lock_wdata_i` = 0 clears `wen_o`. A lock write with data 1 has no effect. Once `wen_o` is 0, interval writes are ignored until reset.
- R5: Outside the FAULT state, each cycle with `tick_i` high adds one to `count_o`, visible after that clock edge.
- R6: `reseed_req_o` rises one clock edge after the count is at or above the interval, and stays high while no acknowledge arrives. An interval of 0 requests at once.
- R7: `reseed_ack_i` while the request is high clears the count to 0 and drops the request at the same edge. An acknowledge without a pending request has no effect on the count.
- R8: The count saturates at 0xFFFF and does not wrap.
- R9: A mismatch between the two count copies sets `fatal_cnt_o`. The flag stays set until reset. After it is set, the request stays low and ticks no longer change the count.
- R10: Disagreement between the stored interval and its inverted shadow copy sets `fatal_shadow_o`. The flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ival_wr_i | input | 1 | Interval write strobe |
| ival_wdata_i | input | 16 | Interval write data |
| lock_wr_i | input | 1 | Lock write strobe |
| lock_wdata_i | input | 1 | Lock write data; 0 clears the write enable |
| tick_i | input | 1 | Generator update pulse |
| reseed_ack_i | input | 1 | Reseed acknowledge |
| ival_o | output | 16 | Committed interval |
| wen_o | output | 1 | Interval write enable |
| count_o | output | 16 | Current update count |
| reseed_req_o | output | 1 | Reseed request |
| recov_err_o | output | 1 | Recoverable shadow-update error pulse |
| fatal_cnt_o | output | 1 | Sticky count-copy mismatch fault |
| fatal_shadow_o | output | 1 | Sticky interval shadow-copy fault |

## Verification
The hardest situations to reach are the fatal faults. The two count copies and the two interval copies are always written together, so no port sequence can make them disagree. The bench therefore forces one internal copy to a wrong value for a single cycle, releases it, and then checks the sticky flag, the low request and the frozen count at the ports. Saturation is the other hard case: it needs 65535 ticks, so the bench programs the largest interval and holds `tick_i` high for a little over that many cycles.

// File: rtl/reseed_guard_pkg.sv
package reseed_guard_pkg;
    typedef enum logic [2:0] {
        RG_COUNT = 3'b011,
        RG_REQ   = 3'b101,
        RG_FAULT = 3'b110
    } rg_state_e;
endpackage

// File: rtl/rg_shadow_reg.sv
module rg_shadow_reg #(
    parameter int unsigned W = 16,
    parameter logic [W-1:0] RST_VAL = 16'h0100
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] value_o,
    output logic         mismatch_o,
    output logic         corrupt_o
);
    logic [W-1:0] stage_q, value_q, inv_q;
    logic         staged_q, mism_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stage_q  <= '0;
            staged_q <= 1'b0;
            value_q  <= RST_VAL;
            inv_q    <= ~RST_VAL;
            mism_q   <= 1'b0;
        end else begin
            mism_q <= 1'b0;
            if (wr_i) begin
                if (!staged_q) begin
                    stage_q  <= wdata_i;
                    staged_q <= 1'b1;
                end else if (wdata_i == stage_q) begin
                    value_q  <= wdata_i;
                    inv_q    <= ~wdata_i;
                    staged_q <= 1'b0;
                end else begin
                    stage_q  <= wdata_i;
                    staged_q <= 1'b1;
                    mism_q   <= 1'b1;
                end
            end
        end
    end

    assign value_o    = value_q;
    assign mismatch_o = mism_q;
    assign corrupt_o  = ((value_q ^ inv_q) != {W{1'b1}});
endmodule

// File: rtl/rg_dual_counter.sv
module rg_dual_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         inc_i,
    input  logic         clr_i,
    output logic [W-1:0] count_o,
    output logic         mismatch_o
);
    logic [W-1:0] cnt_a_q, cnt_b_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_a_q <= '0;
            cnt_b_q <= '0;
        end else if (clr_i) begin
            cnt_a_q <= '0;
            cnt_b_q <= '0;
        end else if (inc_i) begin
            cnt_a_q <= cnt_a_q + 1'b1;
            cnt_b_q <= cnt_b_q + 1'b1;
        end
    end

    assign count_o    = cnt_a_q;
    assign mismatch_o = (cnt_a_q != cnt_b_q);
endmodule

// File: rtl/reseed_guard.sv
module reseed_guard
    import reseed_guard_pkg::*;
#(
    parameter int unsigned W = 16,
    parameter logic [W-1:0] RST_IVAL = 16'h0100
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         ival_wr_i,
    input  logic [W-1:0] ival_wdata_i,
    input  logic         lock_wr_i,
    input  logic         lock_wdata_i,
    input  logic         tick_i,
    input  logic         reseed_ack_i,
    output logic [W-1:0] ival_o,
    output logic         wen_o,
    output logic [W-1:0] count_o,
    output logic         reseed_req_o,
    output logic         recov_err_o,
    output logic         fatal_cnt_o,
    output logic         fatal_shadow_o
);
    localparam logic [W-1:0] CntMax = {W{1'b1}};

    rg_state_e    state_q, state_d;
    logic         wen_q, fatal_cnt_q, fatal_shd_q;
    logic         cnt_inc, cnt_clr, cnt_mism, shd_corrupt;
    logic [W-1:0] ival, count;

    // lock bit: cleared by writing 0, never set again before reset
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                       wen_q <= 1'b1;
        else if (lock_wr_i && !lock_wdata_i) wen_q <= 1'b0;
    end

    rg_shadow_reg #(.W(W), .RST_VAL(RST_IVAL)) u_ival (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_i       (ival_wr_i && wen_q),
        .wdata_i    (ival_wdata_i),
        .value_o    (ival),
        .mismatch_o (recov_err_o),
        .corrupt_o  (shd_corrupt)
    );

    rg_dual_counter #(.W(W)) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .inc_i      (cnt_inc),
        .clr_i      (cnt_clr),
        .count_o    (count),
        .mismatch_o (cnt_mism)
    );

    // sticky fatal flags
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fatal_cnt_q <= 1'b0;
            fatal_shd_q <= 1'b0;
        end else begin
            fatal_cnt_q <= fatal_cnt_q | cnt_mism;
            fatal_shd_q <= fatal_shd_q | shd_corrupt;
        end
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= RG_COUNT;
        else         state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RG_COUNT: if (count >= ival)   state_d = RG_REQ;
            RG_REQ:   if (reseed_ack_i)    state_d = RG_COUNT;
            RG_FAULT: state_d = RG_FAULT;
            default:  state_d = RG_FAULT;
        endcase
        if (fatal_cnt_q || fatal_shd_q) state_d = RG_FAULT;
    end

    // outputs
    always_comb begin
        reseed_req_o = 1'b0;
        cnt_clr      = 1'b0;
        cnt_inc      = 1'b0;
        unique case (state_q)
            RG_COUNT: cnt_inc = tick_i && (count != CntMax);
            RG_REQ: begin
                reseed_req_o = 1'b1;
                cnt_clr      = reseed_ack_i;
                cnt_inc      = tick_i && (count != CntMax);
            end
            default: ;
        endcase
    end

    assign ival_o         = ival;
    assign wen_o          = wen_q;
    assign count_o        = count;
    assign fatal_cnt_o    = fatal_cnt_q;
    assign fatal_shadow_o = fatal_shd_q;
endmodule

// File: rtl/reseed_guard_chk.sv
module reseed_guard_chk #(
    parameter int unsigned W = 16
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic         reseed_ack_i,
    input logic [W-1:0] ival_o,
    input logic         wen_o,
    input logic [W-1:0] count_o,
    input logic         reseed_req_o,
    input logic         recov_err_o,
    input logic         fatal_cnt_o,
    input logic         fatal_shadow_o
);
    AST_LOCK_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wen_o |=> !wen_o); // R4
    AST_LOCKED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wen_o |=> $stable(ival_o)); // R4
    AST_RECOV_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        recov_err_o |=> !recov_err_o); // R3
    AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(reseed_req_o && reseed_ack_i) |=>
            (count_o == $past(count_o)) || (count_o == $past(count_o) + 1'b1)); // R5
    AST_REQ_NEEDS_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(reseed_req_o) |-> $past(count_o) >= $past(ival_o)); // R6
    AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reseed_req_o && reseed_ack_i) |=> (count_o == '0) && !reseed_req_o); // R7
    AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (count_o == {W{1'b1}} && !(reseed_req_o && reseed_ack_i)) |=> count_o == {W{1'b1}}); // R8
    AST_CNT_FAULT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fatal_cnt_o |=> fatal_cnt_o && !reseed_req_o); // R9
    AST_SHD_FAULT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fatal_shadow_o |=> fatal_shadow_o); // R10
endmodule

bind reseed_guard reseed_guard_chk #(.W(W)) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .reseed_ack_i   (reseed_ack_i),
    .ival_o         (ival_o),
    .wen_o          (wen_o),
    .count_o        (count_o),
    .reseed_req_o   (reseed_req_o),
    .recov_err_o    (recov_err_o),
    .fatal_cnt_o    (fatal_cnt_o),
    .fatal_shadow_o (fatal_shadow_o)
);

// File: tb/sim_reseed_guard.sv
`timescale 1ns/1ps
module sim_reseed_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ival_wr = 1'b0, lock_wr = 1'b0, lock_wdata = 1'b0;
    logic        tick = 1'b0, ack = 1'b0;
    logic [15:0] ival_wdata = '0;
    logic [15:0] ival, count;
    logic        wen, req, recov, f_cnt, f_shd;
    int          checks = 0, failures = 0;
    logic [15:0] hold;

    always #5 clk = ~clk;

    reseed_guard u0 (
        .clk_i(clk), .rst_ni(rst_n), .ival_wr_i(ival_wr), .ival_wdata_i(ival_wdata),
        .lock_wr_i(lock_wr), .lock_wdata_i(lock_wdata), .tick_i(tick),
        .reseed_ack_i(ack), .ival_o(ival), .wen_o(wen), .count_o(count),
        .reseed_req_o(req), .recov_err_o(recov), .fatal_cnt_o(f_cnt),
        .fatal_shadow_o(f_shd)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ival_wr = 0; lock_wr = 0; tick = 0; ack = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr_ival(input logic [15:0] d);
        ival_wr = 1'b1; ival_wdata = d;
        @(negedge clk);
        ival_wr = 1'b0;
    endtask

    task automatic wr_lock(input logic d);
        lock_wr = 1'b1; lock_wdata = d;
        @(negedge clk);
        lock_wr = 1'b0;
    endtask

    task automatic one_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic pulse_ack();
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic reset_state_checks();
        check("R1 interval", ival, 16'h0100);
        check("R1 wen", wen, 1);
        check("R1 count", count, 0);
        check("R1 req", req, 0);
        check("R1 errors", {recov, f_cnt, f_shd}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        reset_state_checks();

        // R2: single write stages only, matching second write commits
        wr_ival(16'h0003);
        check("R2 single write no commit", ival, 16'h0100);
        wr_ival(16'h0003);
        check("R2 matching pair commits", ival, 16'h0003);
        check("R2 no recov on match", recov, 0);

        // R3: mismatch discards, pulses recov once, differing write restaged
        wr_ival(16'h0011);
        wr_ival(16'h0022);
        check("R3 interval unchanged", ival, 16'h0003);
        check("R3 recov pulse", recov, 1);
        @(negedge clk);
        check("R3 recov one cycle", recov, 0);
        wr_ival(16'h0022);
        check("R3 restaged value commits", ival, 16'h0022);

        // R7: ack without request has no effect
        one_tick(); one_tick();
        check("R5 two ticks", count, 2);
        pulse_ack();
        check("R7 stray ack ignored", count, 2);
        pulse_ack();
        // R6/R7 sweep over intervals 1..6; reach count 0 by acking a request first
        wr_ival(16'h0001); wr_ival(16'h0001);
        @(negedge clk);
        pulse_ack();
        for (int n = 1; n <= 6; n++) begin
            wr_ival(n[15:0]); wr_ival(n[15:0]);
            @(negedge clk);
            check("R6 no req at start", req, 0);
            for (int k = 1; k <= n + 1; k++) begin
                one_tick();
                check("R5 count per tick", count, k);
                @(negedge clk);
                check("R6 req vs count", req, (k >= n) ? 1 : 0);
            end
            pulse_ack();
            check("R7 ack clears count", count, 0);
            check("R7 ack drops req", req, 0);
        end

        // R6: interval 0 requests at once
        wr_ival(16'h0000); wr_ival(16'h0000);
        @(negedge clk);
        check("R6 zero interval req", req, 1);
        pulse_ack();
        check("R7 ack zero interval", count, 0);
        @(negedge clk);
        check("R6 zero interval re-req", req, 1);

        // R8: saturation at all ones
        wr_ival(16'hFFFF); wr_ival(16'hFFFF);
        pulse_ack();
        tick = 1'b1;
        repeat (65540) @(negedge clk);
        tick = 1'b0;
        check("R8 saturate", count, 16'hFFFF);
        check("R6 req at max", req, 1);
        pulse_ack();
        check("R7 ack after saturate", count, 0);

        // R4: lock behaviour
        wr_lock(1'b1);
        check("R4 lock write 1 no effect", wen, 1);
        wr_lock(1'b0);
        check("R4 lock write 0 clears", wen, 0);
        wr_ival(16'h0042); wr_ival(16'h0042);
        check("R4 locked write ignored", ival, 16'hFFFF);
        check("R4 locked no recov", recov, 0);
        wr_lock(1'b1);
        check("R4 lock stays cleared", wen, 0);

        // R9: counter copy mismatch
        do_reset();
        reset_state_checks();
        wr_ival(16'h0002); wr_ival(16'h0002);
        one_tick();
        force u0.u_cnt.cnt_b_q = 16'h5A5A;
        @(negedge clk);
        release u0.u_cnt.cnt_b_q;
        @(negedge clk);
        check("R9 fatal cnt set", f_cnt, 1);
        check("R9 shadow flag clear", f_shd, 0);
        hold = count;
        repeat (4) one_tick();
        repeat (3) @(negedge clk);
        check("R9 count frozen", count, hold);
        check("R9 no request", req, 0);
        check("R9 sticky", f_cnt, 1);

        // R10: shadow copy corruption
        do_reset();
        reset_state_checks();
        force u0.u_ival.inv_q = 16'h0000;
        @(negedge clk);
        release u0.u_ival.inv_q;
        @(negedge clk);
        check("R10 fatal shadow set", f_shd, 1);
        repeat (3) @(negedge clk);
        check("R10 sticky", f_shd, 1);
        check("R10 cnt flag clear", f_cnt, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule